// File: doc/BRIEF.md
# Extended-Count Quadrature Decoder

This block turns the two phase signals of an incremental encoder into a signed position at four counts per encoder cycle. A narrow up/down counter, which starts at the middle of its range, follows each legal phase edge. When a step would carry it past either end, the counter goes back to its middle value. In the same clock cycle a wide signed accumulator takes in the amount that was dropped. Because both registers change in one edge, their sum is always the true position.

The reported position is the accumulator plus the signed distance of the narrow counter from its middle value. A read strobe copies that sum into a holding register in a single cycle, so a reader never sees a half-applied wrap. A wrong result by half the counter range therefore cannot occur. An optional three-sample glitch filter and an optional index input that zeroes the position are enabled by parameters. Both are off by default.

Top module: `quad_ext_counter`

## Requirements
- R1: Each legal edge on either phase moves the position by exactly one. The {A,B} sequence 00, 10, 11, 01, 00 counts up and the reverse sequence counts down.
- R2: The narrow counter is LOW_W bits wide (default 16) and its initial value is 2^(LOW_W-1). The position equals the accumulator plus the narrow counter minus that initial value.
- R3: An up step taken while the narrow counter is at its all-ones value re-centres the counter. In the same cycle the accumulator gains 2^(LOW_W-1), so the position still rises by exactly one.
- R4: A down step taken while the narrow counter is at zero re-centres the counter. In the same cycle the accumulator loses 2^(LOW_W-1)+1, so the position still falls by exactly one.
- R5: A high rd_i captures the full POS_W-bit position into pos_o at the next clock edge. pos_o does not change in a cycle where rd_i is low.
- R6: When both phases change between two consecutive samples, err_o is set, the position does not change, and err_o stays set until reset.
- R7: With INDEX_EN=1, a rising edge of index_i sets the position to zero. With INDEX_EN=0, index_i has no effect.
- R8: With GLITCH_EN=1, a phase level is taken only after it has been seen for three consecutive samples. A two-cycle pulse on both phases therefore neither counts nor sets err_o, while a four-cycle pulse does set err_o.
- R9: After reset, the position is zero, pos_o is zero and err_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_a_i | input | 1 | Encoder phase A, asynchronous |
| phase_b_i | input | 1 | Encoder phase B, asynchronous |
| index_i | input | 1 | Encoder index, asynchronous, used when INDEX_EN=1 |
| rd_i | input | 1 | Read strobe; captures the position |
| pos_o | output | POS_W | Captured signed position |
| err_o | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest case to reach is a wrap of the narrow counter. With the default width it needs tens of thousands of edges in one direction, and the read has to land right around the re-centre. The bench builds the decoder with a 6-bit narrow counter. It then sweeps forward and backward far enough to cross both ends several times, reading the position every few steps and comparing it with an integer model. Glitch rejection is reached by driving the same pulse stream into a filtered and an unfiltered instance and comparing their error flags.

// File: rtl/qd_pkg.sv
package qd_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;
endpackage

// File: rtl/qd_sync.sv
module qd_sync #(
  parameter int W    = 3,
  parameter bit FILT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  generate
    if (FILT) begin : g_filt
      logic [W-1:0] h1_q, h2_q, f_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          h1_q <= '0;
          h2_q <= '0;
          f_q  <= '0;
        end else begin
          h1_q <= s2_q;
          h2_q <= h1_q;
          for (int i = 0; i < W; i++)
            if (s2_q[i] == h1_q[i] && h1_q[i] == h2_q[i]) f_q[i] <= s2_q[i];
        end
      end
      assign q_o = f_q;
    end else begin : g_raw
      assign q_o = s2_q;
    end
  endgenerate
endmodule

// File: rtl/qd_step.sv
module qd_step
  import qd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  a_i,
  input  logic  b_i,
  input  logic  idx_i,
  output step_e step_o,
  output logic  idx_rise_o
);
  logic pa_q, pb_q, pi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
      pi_q <= 1'b0;
    end else begin
      pa_q <= a_i;
      pb_q <= b_i;
      pi_q <= idx_i;
    end
  end

  always_comb begin
    unique case ({a_i ^ pa_q, b_i ^ pb_q})
      2'b00:   step_o = STEP_NONE;
      2'b11:   step_o = STEP_BAD;
      // A leading B counts up
      default: step_o = (a_i ^ pb_q) ? STEP_UP : STEP_DN;
    endcase
  end

  assign idx_rise_o = idx_i & ~pi_q;

  AST_STEP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == STEP_UP || step_o == STEP_DN) |-> (pa_q ^ a_i) != (pb_q ^ b_i)); // R1
endmodule

// File: rtl/qd_count.sv
module qd_count
  import qd_pkg::*;
#(
  parameter int LOW_W = 16,
  parameter int POS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  step_e            step_i,
  input  logic             clr_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [LOW_W-1:0] INIT  = {1'b1, {(LOW_W-1){1'b0}}};
  localparam logic [LOW_W-1:0] MAXV  = '1;
  localparam logic [POS_W-1:0] HALF  = {{(POS_W-LOW_W){1'b0}}, INIT};
  localparam logic [POS_W-1:0] HALF1 = HALF + POS_W'(1);

  logic [LOW_W-1:0] cnt_q;
  logic [POS_W-1:0] acc_q;
  logic [LOW_W:0]   off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= INIT;
      acc_q <= '0;
    end else if (clr_i) begin
      cnt_q <= INIT;
      acc_q <= '0;
    end else begin
      case (step_i)
        STEP_UP: begin
          if (cnt_q == MAXV) begin
            cnt_q <= INIT;
            acc_q <= acc_q + HALF;
          end else cnt_q <= cnt_q + 1'b1;
        end
        STEP_DN: begin
          if (cnt_q == '0) begin
            cnt_q <= INIT;
            acc_q <= acc_q - HALF1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign off   = {1'b0, cnt_q} - {1'b0, INIT};
  assign pos_o = acc_q + {{(POS_W-LOW_W-1){off[LOW_W]}}, off};

  AST_OVF_RECENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i == STEP_UP && cnt_q == MAXV) |=> (cnt_q == INIT && acc_q == $past(acc_q) + HALF)); // R3
  AST_UNF_RECENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i == STEP_DN && cnt_q == '0) |=> (cnt_q == INIT && acc_q == $past(acc_q) - HALF1)); // R4
  AST_POS_CONTINUOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (pos_o == $past(pos_o) || pos_o == $past(pos_o) + 1'b1 || pos_o == $past(pos_o) - 1'b1)); // R1
endmodule

// File: rtl/quad_ext_counter.sv
module quad_ext_counter
  import qd_pkg::*;
#(
  parameter int LOW_W     = 16,
  parameter int POS_W     = 32,
  parameter bit GLITCH_EN = 1'b0,
  parameter bit INDEX_EN  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             phase_a_i,
  input  logic             phase_b_i,
  input  logic             index_i,
  input  logic             rd_i,
  output logic [POS_W-1:0] pos_o,
  output logic             err_o
);
  logic [2:0]       ph;
  step_e            step;
  logic             idx_rise, clr;
  logic [POS_W-1:0] pos_live;
  logic             err_q;
  logic [POS_W-1:0] hold_q;

  qd_sync #(.W(3), .FILT(GLITCH_EN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({index_i, phase_b_i, phase_a_i}), .q_o(ph)
  );

  qd_step u_step (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_i(ph[0]), .b_i(ph[1]), .idx_i(ph[2]),
    .step_o(step), .idx_rise_o(idx_rise)
  );

  assign clr = INDEX_EN ? idx_rise : 1'b0;

  qd_count #(.LOW_W(LOW_W), .POS_W(POS_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .step_i(step), .clr_i(clr), .pos_o(pos_live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      if (step == STEP_BAD) err_q <= 1'b1;
      if (rd_i) hold_q <= pos_live;
    end
  end

  assign err_o = err_q;
  assign pos_o = hold_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(pos_o)); // R5
  AST_BAD_NO_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == STEP_BAD && !clr) |=> $stable(pos_live)); // R6
endmodule

// File: tb/quad_ext_counter_test.sv
module quad_ext_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, idx = 1'b0, rd = 1'b0;
  logic [31:0] pos_u, pos_f;
  logic err_u, err_f;
  int checks = 0, fails = 0;
  int mpos = 0, mpos_f = 0;
  int st = 0;
  logic [31:0] snap;

  always #10 clk = ~clk;

  quad_ext_counter #(.LOW_W(6), .POS_W(32), .GLITCH_EN(1'b0), .INDEX_EN(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .phase_a_i(pa), .phase_b_i(pb),
    .index_i(idx), .rd_i(rd), .pos_o(pos_u), .err_o(err_u)
  );

  quad_ext_counter #(.LOW_W(6), .POS_W(32), .GLITCH_EN(1'b1), .INDEX_EN(1'b0)) uut_f (
    .clk_i(clk), .rst_ni(rst_n), .phase_a_i(pa), .phase_b_i(pb),
    .index_i(idx), .rd_i(rd), .pos_o(pos_f), .err_o(err_f)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {A,B} up order: 00,10,11,01
  task automatic step(input bit up);
    st = up ? (st + 1) % 4 : (st + 3) % 4;
    case (st)
      0: begin pa = 1'b0; pb = 1'b0; end
      1: begin pa = 1'b1; pb = 1'b0; end
      2: begin pa = 1'b1; pb = 1'b1; end
      default: begin pa = 1'b0; pb = 1'b1; end
    endcase
    if (up) begin mpos++; mpos_f++; end
    else begin mpos--; mpos_f--; end
    wait_n(8);
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic read_chk(input string req);
    do_read();
    chk(req, $signed(pos_u), mpos);
    chk(req, $signed(pos_f), mpos_f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // R9 reset state
    chk("R9 pos_o", $signed(pos_u), 0);
    chk("R9 err_o", int'(err_u), 0);
    read_chk("R9 position");

    // R1/R2 forward sweep, crosses overflow at step 32 (R3)
    for (int i = 1; i <= 40; i++) begin
      step(1'b1);
      if (i % 5 == 0 || i == 31 || i == 32 || i == 33) read_chk(i >= 32 ? "R3" : "R1");
    end
    // backward: crosses underflow (R4) repeatedly
    for (int i = 1; i <= 150; i++) begin
      step(1'b0);
      if (i % 7 == 0) read_chk(mpos < 0 ? "R4" : "R1");
    end
    read_chk("R4");
    // forward again across both limits
    for (int i = 1; i <= 130; i++) begin
      step(1'b1);
      if (i % 9 == 0) read_chk("R3");
    end
    read_chk("R2");

    // R5 hold: no strobe keeps pos_o
    do_read();
    snap = pos_u;
    step(1'b1);
    step(1'b1);
    chk("R5 hold", $signed(pos_u), $signed(snap));
    read_chk("R5 capture");

    // R7 index: uut clears, uut_f ignores
    @(negedge clk); idx = 1'b1;
    wait_n(8);
    idx = 1'b0;
    wait_n(8);
    mpos = 0;
    read_chk("R7");
    step(1'b1); step(1'b1); step(1'b0);
    read_chk("R7 after");

    // R6/R8: two-cycle pulse on both phases
    chk("R6 err before", int'(err_u), 0);
    @(negedge clk); pa = ~pa; pb = ~pb;
    wait_n(2);
    pa = ~pa; pb = ~pb;
    wait_n(10);
    chk("R6 err set", int'(err_u), 1);
    chk("R8 short pulse no err", int'(err_f), 0);
    read_chk("R6 no move");
    wait_n(5);
    chk("R6 sticky", int'(err_u), 1);

    // R8: four-cycle pulse passes filter
    @(negedge clk); pa = ~pa; pb = ~pb;
    wait_n(4);
    pa = ~pa; pb = ~pb;
    wait_n(10);
    chk("R8 long pulse err", int'(err_f), 1);
    read_chk("R8 no move");
    step(1'b0);
    read_chk("R1 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule